// File: doc/BRIEF.md
# Serial Receive Queue with Error Lock

This block is the character-receive path of one serial channel. Received characters enter a small circular queue, and each one carries three error flags: CRC/framing, overrun and parity. The flags sit in a status store that runs beside the data store. The host takes characters through a read strobe. Each accepted read returns the character one cycle later. The same read copies that character's error flags into a readable error register.

A character that carries any error flag locks the queue. Further reads return the same character again until the host issues an error-reset command, which steps past it. When the queue is full, an incoming character is not dropped. It replaces the most recently stored character and tags it with the overrun flag.

A two-bit mode selects how the block raises receive interrupts and special-condition interrupts:

- interrupts off;
- interrupt on the first character only, with a re-arm command;
- interrupt on every character, with parity errors treated as special conditions;
- interrupt on every character, with parity errors not treated as special conditions.

Top module: `rxq_lock_fifo`

## Requirements
- R1: After reset the queue is empty, and `stat_avail`, `stat_err`, `rx_irq` and `spec_irq` are all 0. The first-character interrupt is armed after reset.
- R2: Characters are returned in arrival order. `rd_data` and `stat_err` update on the clock edge that accepts a read. A read is accepted when `rd_strobe` is 1, `stat_avail` is 1 and `cmd_err_reset` is 0.
- R3: The queue holds at most DEPTH-1 characters. A character that arrives when the queue is full replaces the newest stored character and sets that entry's overrun flag. The queue occupancy does not grow.
- R4: A character written to a queue that is not full has its overrun flag cleared, even when its slot previously held an overrun-tagged entry.
- R5: `stat_avail` is 1 from the edge after any received character. It returns to 0 when a read or an error reset leaves the queue empty and unlocked.
- R6: An accepted read loads `stat_err` from the entry's flags. The bit positions are: [2] CRC/framing, [1] overrun, [0] parity.
- R7: If the entry read has any error flag set, the queue locks on it. Repeated reads return the same character and flags, and `stat_avail` stays 1.
- R8: `cmd_err_reset` releases a lock by stepping past the locked entry, and it clears `spec_irq`. When the queue is not locked, the command leaves the queue contents unchanged.
- R9: In mode 2'b01 (first character), a character raises `rx_irq` only if the first-character flag is armed. Raising the interrupt disarms the flag.
- R10: `cmd_arm_next` re-arms the first-character flag.
- R11: In modes 2'b10 and 2'b11, every received character raises `rx_irq`. Any accepted read clears `rx_irq` unless a character arrives in the same cycle.
- R12: In any mode other than 2'b00, reading an entry with the CRC/framing or overrun flag set raises `spec_irq`. A parity flag raises `spec_irq` only in mode 2'b10.
- R13: In mode 2'b00 neither `rx_irq` nor `spec_irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_mode | input | 2 | Receive interrupt mode (00 off, 01 first, 10 all + parity special, 11 all) |
| rx_valid | input | 1 | Strobe: a received character is present |
| rx_data | input | DATA_W | Received character |
| rx_crc_err | input | 1 | CRC/framing error flag for the character |
| rx_par_err | input | 1 | Parity error flag for the character |
| rd_strobe | input | 1 | Host data-read request |
| cmd_err_reset | input | 1 | Error-reset command |
| cmd_arm_next | input | 1 | Re-arm the first-character interrupt |
| rd_data | output | DATA_W | Character returned by the last accepted read |
| stat_err | output | 3 | Error flags of the last read entry |
| stat_avail | output | 1 | Character available |
| rx_irq | output | 1 | Receive interrupt request |
| spec_irq | output | 1 | Special-condition interrupt request |

## Verification
The bench builds the block with its default depth of 3 and an 8-bit data width. At this depth two characters fill the queue, so a third character reaches the overrun path at once. The three slots are also reused within a few writes, which shows that an overrun tag is cleared when its slot is reused. Short sequences therefore cover the lock, the error reset and every interrupt mode.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue: interrupt mode encoding and error flags.
package rxq_pkg;
    typedef enum logic [1:0] {
        RXI_OFF       = 2'b00,
        RXI_FIRST     = 2'b01,
        RXI_ALL_PSPEC = 2'b10,
        RXI_ALL       = 2'b11
    } rxi_mode_e;

    // Packed order gives bit 2 = crc/framing, bit 1 = overrun, bit 0 = parity.
    typedef struct packed {
        logic crc;
        logic ovr;
        logic par;
    } rx_err_t;
endpackage

// File: rtl/rxq_store.sv
// Circular data store with a parallel error-flag store and a read lock.
// Assumes DEPTH >= 3. rd_en is only asserted when a character is present
// and no error reset is requested in the same cycle.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_crc,
    input  logic              wr_par,
    input  logic              rd_en,
    input  logic              err_rst,
    output logic [DATA_W-1:0] rd_data,
    output rx_err_t           rd_err,
    output rx_err_t           head_err,
    output logic              avail
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] dmem [DEPTH];
    rx_err_t           emem [DEPTH];
    logic [PTR_W-1:0]  wp, rp, wp_n, rp_n, ow_slot;
    logic              locked, locked_n, full;

    function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    // Full detection and choice of the slot a write lands in.
    always_comb begin
        full     = (step_up(wp) == rp);
        ow_slot  = full ? step_down(wp) : wp;
        head_err = emem[rp];
    end

    // Slot storage: a full write replaces the newest entry and tags overrun.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                dmem[i] <= '0;
                emem[i] <= '0;
            end else if (wr_en && ow_slot == PTR_W'(i)) begin
                dmem[i] <= wr_data;
                emem[i] <= '{crc: wr_crc, ovr: full, par: wr_par};
            end
        end
    end

    // Next-state of pointers and lock: error reset steps past a locked entry.
    always_comb begin
        wp_n     = (wr_en && !full) ? step_up(wp) : wp;
        rp_n     = rp;
        locked_n = locked;
        if (err_rst && locked) begin
            rp_n     = step_up(rp);
            locked_n = 1'b0;
        end else if (rd_en) begin
            if (|head_err) locked_n = 1'b1;
            else           rp_n     = step_up(rp);
        end
    end

    // Pointer, lock and availability registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp     <= '0;
            rp     <= '0;
            locked <= 1'b0;
            avail  <= 1'b0;
        end else begin
            wp     <= wp_n;
            rp     <= rp_n;
            locked <= locked_n;
            avail  <= (wp_n != rp_n);
        end
    end

    // Read port: character and its flags are captured on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= '0;
        end else if (rd_en) begin
            rd_data <= dmem[rp];
            rd_err  <= head_err;
        end
    end
endmodule

// File: rtl/rxq_irq.sv
// Receive and special-condition interrupt requests for the receive queue.
// Assumes rd_ev marks an accepted read and rd_errs are that entry's flags.
module rxq_irq
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rxi_mode_e mode,
    input  logic      wr_ev,
    input  logic      rd_ev,
    input  rx_err_t   rd_errs,
    input  logic      err_rst,
    input  logic      arm_cmd,
    output logic      rx_irq,
    output logic      spec_irq
);
    logic armed, rx_take, special;

    // Decide whether this cycle's events raise a request.
    always_comb begin
        rx_take = wr_ev && ((mode == RXI_ALL) || (mode == RXI_ALL_PSPEC) ||
                            ((mode == RXI_FIRST) && armed));
        special = (mode != RXI_OFF) &&
                  (rd_errs.crc || rd_errs.ovr ||
                   (rd_errs.par && mode == RXI_ALL_PSPEC));
    end

    // Request and first-character flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq   <= 1'b0;
            spec_irq <= 1'b0;
            armed    <= 1'b1;
        end else begin
            if (rx_take)    rx_irq <= 1'b1;
            else if (rd_ev) rx_irq <= 1'b0;

            if (arm_cmd)                                     armed <= 1'b1;
            else if (wr_ev && mode == RXI_FIRST && armed)    armed <= 1'b0;

            if (err_rst)                spec_irq <= 1'b0;
            else if (rd_ev && special)  spec_irq <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_lock_fifo.sv
// Receive queue top: joins the store and the interrupt logic.
// Assumes one character per rx_valid pulse and reads gated by stat_avail.
module rxq_lock_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        int_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_crc_err,
    input  logic              rx_par_err,
    input  logic              rd_strobe,
    input  logic              cmd_err_reset,
    input  logic              cmd_arm_next,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        stat_err,
    output logic              stat_avail,
    output logic              rx_irq,
    output logic              spec_irq
);
    logic    rd_ev;
    rx_err_t rd_err, head_err;

    // A read counts only when a character is held and no reset command competes.
    always_comb rd_ev = rd_strobe && stat_avail && !cmd_err_reset;

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_valid),
        .wr_data  (rx_data),
        .wr_crc   (rx_crc_err),
        .wr_par   (rx_par_err),
        .rd_en    (rd_ev),
        .err_rst  (cmd_err_reset),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .head_err (head_err),
        .avail    (stat_avail)
    );

    rxq_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (rxi_mode_e'(int_mode)),
        .wr_ev    (rx_valid),
        .rd_ev    (rd_ev),
        .rd_errs  (head_err),
        .err_rst  (cmd_err_reset),
        .arm_cmd  (cmd_arm_next),
        .rx_irq   (rx_irq),
        .spec_irq (spec_irq)
    );

    // Error register is the flag word of the last read entry.
    always_comb stat_err = rd_err;
endmodule

// File: rtl/rxq_lock_fifo_chk.sv
// Port-level properties of the receive queue, bound to its top module.
module rxq_lock_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] int_mode,
    input logic       rx_valid,
    input logic       rd_strobe,
    input logic       cmd_err_reset,
    input logic       stat_avail,
    input logic       rx_irq,
    input logic       spec_irq
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!stat_avail && !rx_irq && !spec_irq));
    // R5
    avail_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> stat_avail);
    // R8
    spec_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_reset |=> !spec_irq);
    // R11
    all_mode_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && int_mode[1]) |=> rx_irq);
    // R12
    spec_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spec_irq) |-> $past(rd_strobe));
    // R13
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode == 2'b00 && !rx_irq && !spec_irq) |=> (!rx_irq && !spec_irq));
endmodule

bind rxq_lock_fifo rxq_lock_fifo_chk u_chk (.*);

// File: tb/rxq_lock_fifo_tb.sv
module rxq_lock_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;

    typedef struct {
        logic [7:0] d;
        logic [2:0] e;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] int_mode;
    logic       rx_valid, rx_crc_err, rx_par_err;
    logic [7:0] rx_data;
    logic       rd_strobe, cmd_err_reset, cmd_arm_next;
    logic [7:0] rd_data;
    logic [2:0] stat_err;
    logic       stat_avail, rx_irq, spec_irq;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    bit   m_locked = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_lock_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .int_mode(int_mode),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_crc_err(rx_crc_err), .rx_par_err(rx_par_err),
        .rd_strobe(rd_strobe), .cmd_err_reset(cmd_err_reset),
        .cmd_arm_next(cmd_arm_next), .rd_data(rd_data),
        .stat_err(stat_err), .stat_avail(stat_avail),
        .rx_irq(rx_irq), .spec_irq(spec_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one character per call; the model mirrors full/overrun rules (R3, R4).
    task automatic push(input logic [7:0] d, input bit crc, input bit par);
        exp_t it;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_crc_err = crc; rx_par_err = par;
        if (exp_q.size() == DEPTH - 1) begin
            it.d = d; it.e = {crc, 1'b1, par};
            exp_q[exp_q.size() - 1] = it;
        end else begin
            it.d = d; it.e = {crc, 1'b0, par};
            exp_q.push_back(it);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_crc_err = 1'b0; rx_par_err = 1'b0;
    endtask

    task automatic read_one();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic err_reset();
        @(negedge clk); cmd_err_reset = 1'b1;
        @(negedge clk); cmd_err_reset = 1'b0;
        if (m_locked) begin
            void'(exp_q.pop_front());
            m_locked = 0;
        end
    endtask

    task automatic arm_next();
        @(negedge clk); cmd_arm_next = 1'b1;
        @(negedge clk); cmd_arm_next = 1'b0;
    endtask

    // Monitor: compares every accepted read against the scoreboard head (R2, R6, R7).
    always @(posedge clk) begin
        if (rst_n && rd_strobe && !cmd_err_reset && exp_q.size() > 0) begin
            exp_t it;
            it = exp_q[0];
            #1;
            chk(rd_data == it.d, "R2 read data order", rd_data, it.d);
            chk(stat_err == it.e, "R6 read error flags", stat_err, it.e);
            if (it.e != 3'b000) m_locked = 1;
            else void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; int_mode = 2'b11;
        rx_valid = 0; rx_data = 0; rx_crc_err = 0; rx_par_err = 0;
        rd_strobe = 0; cmd_err_reset = 0; cmd_arm_next = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_avail == 0, "R1 avail after reset", stat_avail, 0);
        chk(stat_err == 0, "R1 err after reset", stat_err, 0);
        chk(rx_irq == 0 && spec_irq == 0, "R1 irqs after reset", {rx_irq, spec_irq}, 0);

        // Basic order and flag handling in all-character mode.
        push(8'h11, 0, 0);
        chk(stat_avail == 1, "R5 avail after char", stat_avail, 1);
        chk(rx_irq == 1, "R11 rx irq on char", rx_irq, 1);
        push(8'h22, 0, 0);
        read_one();
        chk(rx_irq == 0, "R11 read clears rx irq", rx_irq, 0);
        read_one();
        chk(stat_avail == 0, "R5 avail clears when empty", stat_avail, 0);

        // Overrun: third char replaces the newest stored one (R3) and locks (R7).
        push(8'h33, 0, 0);
        push(8'h44, 0, 0);
        push(8'h55, 0, 0);
        read_one();
        read_one();
        chk(stat_err == 3'b010, "R3 overrun tag on newest", stat_err, 3'b010);
        chk(spec_irq == 1, "R12 overrun is special", spec_irq, 1);
        read_one();
        chk(rd_data == 8'h55, "R7 locked entry repeats", rd_data, 8'h55);
        chk(stat_avail == 1, "R7 avail held while locked", stat_avail, 1);
        err_reset();
        chk(spec_irq == 0, "R8 reset clears special", spec_irq, 0);
        chk(stat_avail == 0, "R8 reset steps past lock", stat_avail, 0);

        // Slot reuse after an overrun tag (R4).
        push(8'h66, 0, 0);
        push(8'h77, 0, 0);
        read_one();
        read_one();
        push(8'h88, 0, 0);
        read_one();
        chk(stat_err == 3'b000, "R4 reused slot overrun cleared", stat_err, 0);

        // Parity not special in mode 11, special in mode 10 (R12).
        push(8'h99, 0, 1);
        read_one();
        chk(stat_err == 3'b001, "R6 parity flag bit 0", stat_err, 3'b001);
        chk(spec_irq == 0, "R12 parity not special in 11", spec_irq, 0);
        err_reset();
        int_mode = 2'b10;
        push(8'hA5, 0, 1);
        read_one();
        chk(spec_irq == 1, "R12 parity special in 10", spec_irq, 1);
        err_reset();
        push(8'h5A, 1, 0);
        read_one();
        chk(stat_err == 3'b100, "R6 crc flag bit 2", stat_err, 3'b100);
        err_reset();

        // Error reset without a lock leaves contents (R8).
        push(8'h3C, 0, 0);
        err_reset();
        chk(stat_avail == 1, "R8 unlocked reset no effect", stat_avail, 1);
        read_one();
        chk(rd_data == 8'h3C, "R8 char kept", rd_data, 8'h3C);

        // First-character mode and re-arm (R9, R10).
        int_mode = 2'b01;
        push(8'hC3, 0, 0);
        chk(rx_irq == 1, "R9 first char raises irq", rx_irq, 1);
        read_one();
        push(8'hD4, 0, 0);
        chk(rx_irq == 0, "R9 disarmed no irq", rx_irq, 0);
        read_one();
        arm_next();
        push(8'hE5, 0, 0);
        chk(rx_irq == 1, "R10 re-arm raises irq", rx_irq, 1);
        read_one();

        // Interrupts off (R13).
        int_mode = 2'b00;
        push(8'hF6, 1, 0);
        chk(rx_irq == 0, "R13 no rx irq when off", rx_irq, 0);
        read_one();
        chk(spec_irq == 0, "R13 no special when off", spec_irq, 0);
        err_reset();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule